// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the read and write strobes of one parallel ATA channel for programmed-I/O and multiword DMA cycles. Two devices share the channel, and each has its own 32-bit timing word. The word holds two sets of counts: one for data-port cycles and one for task-file register cycles. Each set has a setup count, a strobe-active count and a strobe-recovery count. A host request names the device, the access class, the direction and the burst length. The block then runs the strobe through the cycles of the burst and returns a one-clock completion pulse.

Each cycle of a burst has an active phase with the strobe low, followed by a recovery phase with the strobe high. The setup delay is inserted once, ahead of the first cycle only. The read strobe samples the bus on the last clock of its active phase. Timing words can be written at any time. A transfer runs on the copy it took when it was accepted. The four enable flags at the top of each word are only decoded and presented as outputs. An engine-reset input abandons a transfer at the next clock edge.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `xfer_done` and `rd_valid` are low, `req_ready` is high, and every flag output is 0.
- R2: A data-class cycle holds its strobe low for word bits [8:4] + 1 clocks, then high for word bits [3:0] + 1 clocks of recovery.
- R3: A task-file (command-class) cycle holds its strobe low for word bits [17:13] + 1 clocks, then high for word bits [12:9] + 1 clocks of recovery.
- R4: Before the first cycle of a request, both strobes stay high for a number of setup clocks. The count comes from bits [24:22] for data class and bits [27:25] for command class, and a value of 0 inserts no setup. Later cycles of the same burst have no setup.
- R5: A request with `req_len` = N runs N + 1 cycles. A read (`req_write` = 0) pulses only `rd_strobe_n` and a write pulses only `wr_strobe_n`. The two strobes are never low together.
- R6: The timing word used is the one of the device given by `req_dev` (0 or 1) at acceptance.
- R7: For a read, `rd_data` takes the value `bus_rdata` had on the last clock of each active phase, and `rd_valid` is high for the one clock after it. Writes never raise `rd_valid`.
- R8: `req_ready` is high only while idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` while busy has no effect. `xfer_done` is high for exactly one clock, directly after the last recovery clock of the burst, and `req_ready` is already high in that clock.
- R9: A timing-word write does not alter a transfer already accepted. The new counts take effect from the next accepted request.
- R10: `eng_reset` high on a clock edge returns the block to idle at that edge. Both strobes go high and `req_ready` rises, with no `xfer_done` and no capture.
- R11: Bits 28, 29, 30 and 31 of a device's word appear on bit d of `udma_en`, `dma_en`, `pio_master` and `fifo_en`. They follow the written word from the clock after the write, whether or not a transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing-word write strobe |
| cfg_dev | input | 1 | Device whose timing word is written |
| cfg_word | input | 32 | Timing word value |
| eng_reset | input | 1 | Engine reset: abandon any transfer |
| req_valid | input | 1 | Transfer request |
| req_dev | input | 1 | Device selected by the request |
| req_cmd | input | 1 | 1 = task-file register class, 0 = data-port class |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | 8 | Burst length minus one |
| req_ready | output | 1 | Idle, request can be taken |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| bus_rdata | input | 16 | Data bus value from the device |
| rd_data | output | 16 | Last captured read word |
| rd_valid | output | 1 | One-clock pulse: new `rd_data` |
| xfer_done | output | 1 | One-clock completion pulse |
| udma_en | output | 2 | Per-device Ultra DMA enable flag |
| dma_en | output | 2 | Per-device DMA enable flag |
| pio_master | output | 2 | Per-device bus-master-during-PIO flag |
| fifo_en | output | 2 | Per-device FIFO enable flag |

## Verification
A behavioural model in the bench expands every accepted request into a per-clock list of expected strobe, ready, done and capture values. It compares that list with the ports on every clock. The requests include the following:
- a data read and a multi-cycle data write with non-zero setup, which separate first-cycle setup from the setup-free later cycles;
- command-class bursts with a long setup and with zero setup, which separate the two field sets;
- an all-zero-field device, which shows one-clock phases and checks the device select.

Timing-word rewrites during a transfer, requests raised while busy, an engine reset in mid-burst and back-to-back requests taken in the done clock separate the latching, ignore and abort rules.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

    localparam int TWORD_W = 32;
    localparam int CNT_W   = 5;

    // Timing word layout, most significant field first.
    typedef struct packed {
        logic       fifo_en;     // 31
        logic       pio_master;  // 30
        logic       dma_en;      // 29
        logic       udma_en;     // 28
        logic [2:0] cmd_setup;   // 27:25
        logic [2:0] dat_setup;   // 24:22
        logic [3:0] udma_rsvd;   // 21:18, not used by this block
        logic [4:0] cmd_low;     // 17:13
        logic [3:0] cmd_high;    // 12:9
        logic [4:0] dat_low;     // 8:4
        logic [3:0] dat_high;    // 3:0
    } tword_t;

    // Counts for one access class.
    typedef struct packed {
        logic [2:0] setup;
        logic [4:0] low;
        logic [3:0] high;
    } phase_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACT,
        PH_REC
    } phase_t;

    // Active-low strobe pair {read, write} for a phase and direction.
    function automatic logic [1:0] strobes_n(phase_t ph, logic is_wr);
        logic act;
        act = (ph == PH_ACT);
        return {~(act & ~is_wr), ~(act & is_wr)};
    endfunction

endpackage

// File: rtl/ata_timing_bank.sv
module ata_timing_bank
    import ata_strobe_pkg::*;
#(
    parameter  int NDEV  = 2,
    localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [DEV_W-1:0]    cfg_dev,
    input  logic [TWORD_W-1:0]  cfg_word,
    input  logic [DEV_W-1:0]    sel_dev,
    output phase_cfg_t          sel_dat,
    output phase_cfg_t          sel_cmd,
    output logic [NDEV-1:0]     udma_en,
    output logic [NDEV-1:0]     dma_en,
    output logic [NDEV-1:0]     pio_master,
    output logic [NDEV-1:0]     fifo_en
);

    tword_t words [NDEV];

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        tword_t word_q;
        logic   unused_rsvd;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (cfg_we && (cfg_dev == DEV_W'(d))) begin
                word_q <= tword_t'(cfg_word);
            end
        end

        assign words[d]      = word_q;
        assign unused_rsvd   = ^word_q.udma_rsvd;
        assign udma_en[d]    = word_q.udma_en;
        assign dma_en[d]     = word_q.dma_en;
        assign pio_master[d] = word_q.pio_master;
        assign fifo_en[d]    = word_q.fifo_en;
    end

    assign sel_dat = '{setup: words[sel_dev].dat_setup,
                       low:   words[sel_dev].dat_low,
                       high:  words[sel_dev].dat_high};
    assign sel_cmd = '{setup: words[sel_dev].cmd_setup,
                       low:   words[sel_dev].cmd_low,
                       high:  words[sel_dev].cmd_high};

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable({udma_en, dma_en, pio_master, fifo_en})); // R11

endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
    import ata_strobe_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eng_reset,
    input  logic              start,
    input  logic              start_cmd,
    input  logic              start_write,
    input  logic [LEN_W-1:0]  start_len,
    input  phase_cfg_t        start_dat,
    input  phase_cfg_t        start_cmd_cfg,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              idle,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    phase_t            ph;
    phase_cfg_t        cur;
    phase_cfg_t        pick;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  left;
    logic              is_wr;
    logic              done_q;
    logic              rdv_q;
    logic [DATA_W-1:0] rdata_q;

    assign pick = start_cmd ? start_cmd_cfg : start_dat;

    always_ff @(posedge clk) begin
        if (rst || eng_reset) begin
            ph      <= PH_IDLE;
            cur     <= '0;
            cnt     <= '0;
            left    <= '0;
            is_wr   <= 1'b0;
            done_q  <= 1'b0;
            rdv_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            rdv_q  <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (start) begin
                        cur   <= pick;
                        is_wr <= start_write;
                        left  <= start_len;
                        if (pick.setup != '0) begin
                            ph  <= PH_SETUP;
                            cnt <= {2'b00, pick.setup} - CNT_W'(1);
                        end else begin
                            ph  <= PH_ACT;
                            cnt <= pick.low;
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= PH_ACT;
                        cnt <= cur.low;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_ACT: begin
                    if (cnt == '0) begin
                        ph  <= PH_REC;
                        cnt <= {1'b0, cur.high};
                        if (!is_wr) begin
                            rdata_q <= bus_rdata;
                            rdv_q   <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_REC: begin
                    if (cnt == '0) begin
                        if (left == '0) begin
                            ph     <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            left <= left - LEN_W'(1);
                            ph   <= PH_ACT;
                            cnt  <= cur.low;
                        end
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign idle         = (ph == PH_IDLE);
    assign {rd_n, wr_n} = strobes_n(ph, is_wr);
    assign done         = done_q;
    assign rd_valid     = rdv_q;
    assign rd_data      = rdata_q;

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        rd_n || wr_n); // R5

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst || eng_reset)
        done |=> !done); // R8

    AST_CAPTURE_AFTER_ACT: assert property (@(posedge clk) disable iff (rst || eng_reset)
        rd_valid |-> $past(!rd_n)); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst || eng_reset)
        (ph != PH_IDLE && $past(ph != PH_IDLE)) |-> $stable(cur)); // R9

    AST_ENG_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        eng_reset |=> (rd_n && wr_n && idle && !done && !rd_valid)); // R10

endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
    import ata_strobe_pkg::*;
#(
    parameter  int NDEV   = 2,
    parameter  int LEN_W  = 8,
    parameter  int DATA_W = 16,
    localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [DEV_W-1:0]   cfg_dev,
    input  logic [TWORD_W-1:0] cfg_word,
    input  logic               eng_reset,
    input  logic               req_valid,
    input  logic [DEV_W-1:0]   req_dev,
    input  logic               req_cmd,
    input  logic               req_write,
    input  logic [LEN_W-1:0]   req_len,
    output logic               req_ready,
    output logic               rd_strobe_n,
    output logic               wr_strobe_n,
    input  logic [DATA_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               xfer_done,
    output logic [NDEV-1:0]    udma_en,
    output logic [NDEV-1:0]    dma_en,
    output logic [NDEV-1:0]    pio_master,
    output logic [NDEV-1:0]    fifo_en
);

    phase_cfg_t sel_dat;
    phase_cfg_t sel_cmd;
    logic       seq_idle;
    logic       accept;

    assign accept    = req_valid && seq_idle;
    assign req_ready = seq_idle;

    ata_timing_bank #(.NDEV(NDEV)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_dev    (cfg_dev),
        .cfg_word   (cfg_word),
        .sel_dev    (req_dev),
        .sel_dat    (sel_dat),
        .sel_cmd    (sel_cmd),
        .udma_en    (udma_en),
        .dma_en     (dma_en),
        .pio_master (pio_master),
        .fifo_en    (fifo_en)
    );

    ata_phase_seq #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .eng_reset     (eng_reset),
        .start         (accept),
        .start_cmd     (req_cmd),
        .start_write   (req_write),
        .start_len     (req_len),
        .start_dat     (sel_dat),
        .start_cmd_cfg (sel_cmd),
        .bus_rdata     (bus_rdata),
        .idle          (seq_idle),
        .rd_n          (rd_strobe_n),
        .wr_n          (wr_strobe_n),
        .done          (xfer_done),
        .rd_data       (rd_data),
        .rd_valid      (rd_valid)
    );

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (accept && !eng_reset) |=> !req_ready); // R8

endmodule

// File: tb/ata_strobe_gen_bench.sv
module ata_strobe_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_dev = '0;
    logic [31:0] cfg_word = '0;
    logic        eng_reset = 1'b0;
    logic        req_valid = 1'b0;
    logic [0:0]  req_dev = '0;
    logic        req_cmd = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_len = '0;
    logic        req_ready;
    logic        rd_strobe_n, wr_strobe_n;
    logic [15:0] bus_rdata = 16'h0;
    logic [15:0] rd_data;
    logic        rd_valid, xfer_done;
    logic [1:0]  udma_en, dma_en, pio_master, fifo_en;

    always #5 clk = ~clk;

    ata_strobe_gen u_ata_strobe_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_word(cfg_word),
        .eng_reset(eng_reset), .req_valid(req_valid), .req_dev(req_dev), .req_cmd(req_cmd),
        .req_write(req_write), .req_len(req_len), .req_ready(req_ready),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n), .bus_rdata(bus_rdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .xfer_done(xfer_done),
        .udma_en(udma_en), .dma_en(dma_en), .pio_master(pio_master), .fifo_en(fifo_en)
    );

    int n_chk  = 0;
    int n_fail = 0;
    string tag = "R1";

    // Expected entry per clock: {rd_n, wr_n, done, ready, capture}
    logic [4:0]  exp_q[$];
    logic [31:0] word_mdl[2];
    logic        chk_on = 1'b0;
    logic        pend_cap = 1'b0;
    logic [15:0] exp_data = '0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(int dh, int dl, int ch, int cl, int ds, int cs,
                                        logic [3:0] fl);
        logic [31:0] w;
        w = '0;
        w[3:0]   = 4'(dh);
        w[8:4]   = 5'(dl);
        w[12:9]  = 4'(ch);
        w[17:13] = 5'(cl);
        w[24:22] = 3'(ds);
        w[27:25] = 3'(cs);
        w[31:28] = fl;
        return w;
    endfunction

    task automatic push_req(input int dev, input bit cmd, input bit wr, input int len);
        logic [31:0] w;
        int s, lo, hi;
        w  = word_mdl[dev];
        s  = cmd ? int'(w[27:25]) : int'(w[24:22]);
        lo = cmd ? int'(w[17:13]) : int'(w[8:4]);
        hi = cmd ? int'(w[12:9])  : int'(w[3:0]);
        for (int i = 0; i < s; i++) exp_q.push_back(5'b11000);
        for (int c = 0; c <= len; c++) begin
            for (int a = 0; a <= lo; a++)
                exp_q.push_back(wr ? 5'b10000 : {4'b0100, (a == lo)});
            for (int h = 0; h <= hi; h++) exp_q.push_back(5'b11000);
        end
        exp_q.push_back(5'b11110);
    endtask

    // Reference model, compared on every clock.
    always @(negedge clk) begin
        logic [4:0] e;
        if (chk_on) begin
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 5'b11010;
            chk(rd_strobe_n == e[4], tag, "read strobe", rd_strobe_n, e[4]);
            chk(wr_strobe_n == e[3], tag, "write strobe", wr_strobe_n, e[3]);
            chk(xfer_done == e[2], "R8", "done pulse", xfer_done, e[2]);
            chk(req_ready == e[1], "R8", "ready", req_ready, e[1]);
            if (pend_cap) begin
                chk(rd_valid == 1'b1, "R7", "rd_valid", rd_valid, 1);
                chk(rd_data == exp_data, "R7", "rd_data", rd_data, exp_data);
            end else begin
                chk(rd_valid == 1'b0, "R7", "rd_valid idle", rd_valid, 0);
            end
            pend_cap  = 1'b0;
            bus_rdata = bus_rdata + 16'h1357;
            if (e[0]) begin
                pend_cap = 1'b1;
                exp_data = bus_rdata;
            end
            if (!rst && !eng_reset && req_valid && req_ready)
                push_req(int'(req_dev), req_cmd, req_write, int'(req_len));
            if (!rst && eng_reset) begin
                exp_q.delete();
                pend_cap = 1'b0;
            end
        end
        if (rst) begin
            word_mdl[0] = '0;
            word_mdl[1] = '0;
        end else if (cfg_we) begin
            word_mdl[cfg_dev] = cfg_word;
        end
    end

    task automatic write_cfg(input int dev, input logic [31:0] w);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_dev = 1'(dev); cfg_word = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic issue(input int dev, input bit cmd, input bit wr, input int len);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b1; req_dev = 1'(dev); req_cmd = cmd; req_write = wr; req_len = 8'(len);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not end, actual 1 expected 0");
        finish_run();
    end

    initial begin
        @(posedge clk);
        chk_on = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rd_strobe_n && wr_strobe_n, "R1", "strobes after reset", {rd_strobe_n, wr_strobe_n}, 3);
        chk(!xfer_done && !rd_valid, "R1", "pulses after reset", {xfer_done, rd_valid}, 0);
        chk(req_ready, "R1", "ready after reset", req_ready, 1);
        chk({udma_en, dma_en, pio_master, fifo_en} == '0, "R1", "flags after reset",
            {udma_en, dma_en, pio_master, fifo_en}, 0);

        write_cfg(0, mkw(2, 3, 0, 1, 2, 0, 4'b1001));
        write_cfg(1, mkw(0, 0, 5, 6, 0, 7, 4'b0110));
        @(negedge clk);
        chk(udma_en == 2'b01, "R11", "udma flags", udma_en, 2'b01);
        chk(dma_en == 2'b10, "R11", "dma flags", dma_en, 2'b10);
        chk(pio_master == 2'b10, "R11", "pio master flags", pio_master, 2'b10);
        chk(fifo_en == 2'b01, "R11", "fifo flags", fifo_en, 2'b01);

        tag = "R2"; issue(0, 0, 0, 0); drain();
        tag = "R4"; issue(0, 0, 1, 3); drain();
        tag = "R3"; issue(1, 1, 0, 1); drain();
        tag = "R4"; issue(0, 1, 1, 2); drain();
        tag = "R6"; issue(1, 0, 0, 2); drain();
        tag = "R5"; issue(1, 0, 1, 4); drain();

        // R8: a request raised while busy is ignored
        tag = "R8";
        issue(1, 1, 1, 0);
        repeat (3) @(posedge clk);
        #1 req_valid = 1'b1; req_dev = 1'b0; req_cmd = 1'b0; req_write = 1'b0; req_len = 8'd5;
        @(negedge clk);
        chk(!req_ready, "R8", "ready while busy", req_ready, 0);
        repeat (4) @(posedge clk);
        #1 req_valid = 1'b0;
        drain();

        // R8: back-to-back requests taken in the done clock
        issue(0, 1, 0, 0);
        issue(1, 0, 1, 1);
        drain();

        // R9: rewrite during transfer, new values on next request
        tag = "R9";
        issue(0, 0, 0, 2);
        write_cfg(0, mkw(1, 7, 0, 1, 1, 0, 4'b0010));
        @(negedge clk);
        chk(dma_en == 2'b11, "R11", "dma flag mid-transfer", dma_en, 2'b11);
        chk(udma_en == 2'b00, "R11", "udma flag mid-transfer", udma_en, 2'b00);
        drain();
        issue(0, 0, 0, 1); drain();

        // R10: engine reset mid-burst
        tag = "R10";
        issue(1, 1, 0, 2);
        repeat (10) @(negedge clk);
        chk(!rd_strobe_n, "R10", "strobe active before reset", rd_strobe_n, 0);
        @(posedge clk); #1 eng_reset = 1'b1;
        @(posedge clk); #1 eng_reset = 1'b0;
        @(negedge clk);
        chk(rd_strobe_n && wr_strobe_n, "R10", "strobes after engine reset",
            {rd_strobe_n, wr_strobe_n}, 3);
        chk(req_ready && !xfer_done, "R10", "idle after engine reset",
            {req_ready, xfer_done}, 2);
        issue(1, 0, 0, 0); drain();

        finish_run();
    end

endmodule